// File: doc/BRIEF.md
# Masked Register Writeback Merger

This block is the commit stage for one executed instruction packet. On a commit strobe it takes a small queue of 32-bit register writes and applies them in a single cycle. Each write carries a target kind, an index, a bit mask and a value. The same strobe also applies a few full-width 64-bit accumulator writes and an optional trap. The architectural state it holds is a general register file, a status word, a backup status word, a debug status word, a pair of accumulators and two banked stack pointers. The live stack pointer is the highest-numbered general register.

Parallel instructions in one packet can both update the arithmetic flags in the status word. When they do, the write that sits later in the queue wins the shared flags. A later update of the overflow flag also cancels an earlier update of the accumulated-overflow flag. A packet whose first slot was a move to a system register skips this arbitration. After the queued writes, a trap can snapshot the status word into the backup or debug copy and then reduce it. Whenever the status word may have changed, its stack-mode bit picks the active stack-pointer bank, and the live pointer is swapped when that pick changes.

Top module: `wbm_top`

## Requirements
- R1: After a synchronous active-high reset, every general register, accumulator, status word, backup and debug status word and both stack banks read zero, and the bank select is 0.
- R2: Only while `commit_i` is high, slots 0 to `wr_count_i`-1 are applied. Each slot updates its target as (old & ~mask) | (value & mask). Kind codes are 0 general register (selected by the index), 1 status word, 2 backup status word and 3 debug status word.
- R3: Slots are applied in ascending slot order, and each one merges into the result of the slots before it. Where two writes to the same target overlap, the later slot's bits stand.
- R4: Status bits are numbered from the MSB, so bit n is 0x80000000 >> n. The flags are F0=17, F1=19, F2=21, F3=23, S=25, V=27, VA=29 and C=31. Suppose an earlier applied status-word write shares at least one flag bit with a later applied status-word write's mask. Then the earlier write loses the flags that the two share. The overlap test uses the earlier write's original mask and covers every later slot.
- R5: When such an overlapping later status write also has V (bit 27) in its mask, the earlier write also loses its VA (bit 29) update, even when the later mask lacks VA.
- R6: With `sys_move_i` high, R4 and R5 do not apply, and status-word writes merge like any other target.
- R7: Accumulator slots 0 to `acc_count_i`-1 replace the whole selected 64-bit accumulator in ascending order, so the later slot wins on the same index.
- R8: Trap code 1 (applied after the queued writes) copies the status word into the backup status word. It then clears every status bit except DB (bit 3) and SM (bit 0).
- R9: Trap code 2 copies the status word into the debug status word and leaves the status word as DS (bit 4) alone. Trap codes 0 and 3 take no trap action.
- R10: After any commit that has an applied status-word write or a trap, the bank select becomes the final SM bit. When the select changes, the live stack pointer (the last general register, after the queued writes) is stored into the old bank, and the live pointer is reloaded from the new bank.
- R11: A cycle without `commit_i` changes no state, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_i | input | 1 | Commit the presented packet this cycle |
| wr_count_i | input | $clog2(NSLOT+1) | Number of valid 32-bit write slots |
| wr_kind_i | input | 2*NSLOT | Target kind per slot, slot 0 in the low bits |
| wr_idx_i | input | IW*NSLOT | General register index per slot |
| wr_mask_i | input | 32*NSLOT | Bit mask per slot |
| wr_data_i | input | 32*NSLOT | Write value per slot |
| sys_move_i | input | 1 | First slot was a move to a system register (disables flag arbitration) |
| acc_count_i | input | $clog2(NACCW+1) | Number of valid accumulator write slots |
| acc_idx_i | input | AIW*NACCW | Accumulator index per slot |
| acc_data_i | input | 64*NACCW | Accumulator value per slot |
| trap_i | input | 2 | Trap code: 0 none, 1 ordinary, 2 debug, 3 none |
| gpr_o | output | 32*NGPR | General register file, register 0 in the low bits |
| acc_o | output | 64*NACC | Accumulators, accumulator 0 in the low bits |
| psw_o | output | 32 | Status word |
| bpsw_o | output | 32 | Backup status word |
| dpsw_o | output | 32 | Debug status word |
| sp_bank_o | output | 64 | Stack banks, bank 1 in the high half |
| sp_sel_o | output | 1 | Active stack bank |

## Verification
The bench builds the block with four general registers, four write slots and two accumulators with two accumulator slots. With that configuration every slot can hit every target kind, and four status writes can collide on the flags in all orderings. Directed packets pin down the flag-overlap and V-implies-VA suppression, the system-move bypass, each trap code and a stack-bank swap. A long run of random packets is then biased toward shared flag masks and stack-mode changes, and each one is compared against a sequential merge model.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    typedef enum logic [1:0] {
        TGT_GPR  = 2'd0,
        TGT_PSW  = 2'd1,
        TGT_BPSW = 2'd2,
        TGT_DPSW = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        TRAP_NONE = 2'd0,
        TRAP_ORD  = 2'd1,
        TRAP_DBG  = 2'd2,
        TRAP_RSV  = 2'd3
    } trap_e;

    // status bit positions, counted from the MSB
    localparam int P_SM = 0;
    localparam int P_DB = 3;
    localparam int P_DS = 4;
    localparam int P_F0 = 17;
    localparam int P_F1 = 19;
    localparam int P_F2 = 21;
    localparam int P_F3 = 23;
    localparam int P_S  = 25;
    localparam int P_V  = 27;
    localparam int P_VA = 29;
    localparam int P_C  = 31;

    localparam logic [31:0] TOP = 32'h8000_0000;
    localparam logic [31:0] BIT_SM = TOP >> P_SM;
    localparam logic [31:0] BIT_DB = TOP >> P_DB;
    localparam logic [31:0] BIT_DS = TOP >> P_DS;
    localparam logic [31:0] BIT_V  = TOP >> P_V;
    localparam logic [31:0] BIT_VA = TOP >> P_VA;
    localparam logic [31:0] FLAG_BITS = (TOP >> P_F0) | (TOP >> P_F1) | (TOP >> P_F2) |
                                        (TOP >> P_F3) | (TOP >> P_S)  | BIT_V |
                                        BIT_VA | (TOP >> P_C);
    localparam int SM_LSB = 31 - P_SM;

    function automatic logic [31:0] masked_merge(input logic [31:0] old_v,
                                                 input logic [31:0] mask,
                                                 input logic [31:0] val);
        return (old_v & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/wbm_flag_arbiter.sv
module wbm_flag_arbiter
    import wbm_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic [NSLOT-1:0]       slot_live,
    input  logic [NSLOT-1:0]       slot_psw,
    input  logic                   bypass,
    input  logic [NSLOT-1:0][31:0] raw_mask,
    output logic [NSLOT-1:0][31:0] eff_mask
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [31:0] drop;
        logic [31:0] shared;
        always_comb begin
            drop = '0;
            shared = '0;
            for (int j = 0; j < NSLOT; j++) begin
                shared = raw_mask[j] & raw_mask[i] & FLAG_BITS;
                if (j > i && slot_live[j] && slot_psw[j] && shared != '0) begin
                    drop = drop | shared;
                    if ((raw_mask[j] & BIT_V) != '0)
                        drop = drop | BIT_VA;
                end
            end
            if (slot_live[i] && slot_psw[i] && !bypass)
                eff_mask[i] = raw_mask[i] & ~drop;
            else
                eff_mask[i] = raw_mask[i];
        end

        // only flag bits may ever be removed from a slot's mask
        always_comb begin
            assert_mask_narrow_R4: assert ((eff_mask[i] & ~raw_mask[i]) == '0 &&
                                           ((raw_mask[i] & ~FLAG_BITS) & ~eff_mask[i]) == '0)
                else $error("effective mask widened or lost non-flag bits");
        end
    end

endmodule

// File: rtl/wbm_trap_stack.sv
module wbm_trap_stack
    import wbm_pkg::*;
(
    input  trap_e            trap,
    input  logic             psw_touched,
    input  logic [31:0]      psw_in,
    input  logic [31:0]      bpsw_in,
    input  logic [31:0]      dpsw_in,
    input  logic [31:0]      sp_in,
    input  logic [1:0][31:0] bank_in,
    input  logic             sel_in,
    output logic [31:0]      psw_out,
    output logic [31:0]      bpsw_out,
    output logic [31:0]      dpsw_out,
    output logic [31:0]      sp_out,
    output logic [1:0][31:0] bank_out,
    output logic             sel_out
);

    logic check_bank;
    logic want_sel;

    always_comb begin
        psw_out  = psw_in;
        bpsw_out = bpsw_in;
        dpsw_out = dpsw_in;
        unique case (trap)
            TRAP_ORD: begin
                bpsw_out = psw_in;
                psw_out  = psw_in & (BIT_DB | BIT_SM);
            end
            TRAP_DBG: begin
                dpsw_out = psw_in;
                psw_out  = BIT_DS;
            end
            default: ;
        endcase
    end

    assign check_bank = psw_touched || trap == TRAP_ORD || trap == TRAP_DBG;
    assign want_sel   = psw_out[SM_LSB];

    always_comb begin
        bank_out = bank_in;
        sp_out   = sp_in;
        sel_out  = sel_in;
        if (check_bank && want_sel != sel_in) begin
            bank_out[sel_in] = sp_in;
            sp_out           = bank_in[want_sel];
            sel_out          = want_sel;
        end
    end

endmodule

// File: rtl/wbm_top.sv
module wbm_top
    import wbm_pkg::*;
#(
    parameter int NGPR  = 8,
    parameter int NSLOT = 4,
    parameter int NACC  = 2,
    parameter int NACCW = 2,
    localparam int IW   = (NGPR > 1) ? $clog2(NGPR) : 1,
    localparam int AIW  = (NACC > 1) ? $clog2(NACC) : 1,
    localparam int CW   = $clog2(NSLOT + 1),
    localparam int ACW  = $clog2(NACCW + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit_i,
    input  logic [CW-1:0]        wr_count_i,
    input  logic [2*NSLOT-1:0]   wr_kind_i,
    input  logic [IW*NSLOT-1:0]  wr_idx_i,
    input  logic [32*NSLOT-1:0]  wr_mask_i,
    input  logic [32*NSLOT-1:0]  wr_data_i,
    input  logic                 sys_move_i,
    input  logic [ACW-1:0]       acc_count_i,
    input  logic [AIW*NACCW-1:0] acc_idx_i,
    input  logic [64*NACCW-1:0]  acc_data_i,
    input  logic [1:0]           trap_i,
    output logic [32*NGPR-1:0]   gpr_o,
    output logic [64*NACC-1:0]   acc_o,
    output logic [31:0]          psw_o,
    output logic [31:0]          bpsw_o,
    output logic [31:0]          dpsw_o,
    output logic [63:0]          sp_bank_o,
    output logic                 sp_sel_o
);

    logic [NGPR-1:0][31:0] gpr_q, gpr_w, gpr_n;
    logic [NACC-1:0][63:0] acc_q, acc_n;
    logic [31:0]           psw_q, bpsw_q, dpsw_q;
    logic [31:0]           psw_w, bpsw_w, dpsw_w;
    logic [31:0]           psw_n, bpsw_n, dpsw_n, sp_n;
    logic [1:0][31:0]      bank_q, bank_n;
    logic                  sel_q, sel_n;

    logic [NSLOT-1:0]       live, is_psw;
    logic [NSLOT-1:0][31:0] raw_mask, eff_mask;
    logic                   psw_touched;
    trap_e                  trap;

    assign trap = trap_e'(commit_i ? trap_i : TRAP_NONE);

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            live[i]     = commit_i && (int'(wr_count_i) > i);
            is_psw[i]   = tgt_e'(wr_kind_i[2*i +: 2]) == TGT_PSW;
            raw_mask[i] = wr_mask_i[32*i +: 32];
        end
    end

    wbm_flag_arbiter #(.NSLOT(NSLOT)) u_arb (
        .slot_live(live),
        .slot_psw (is_psw),
        .bypass   (sys_move_i),
        .raw_mask (raw_mask),
        .eff_mask (eff_mask)
    );

    // queued 32-bit writes, slot order
    always_comb begin
        gpr_w       = gpr_q;
        psw_w       = psw_q;
        bpsw_w      = bpsw_q;
        dpsw_w      = dpsw_q;
        psw_touched = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (live[i]) begin
                unique case (tgt_e'(wr_kind_i[2*i +: 2]))
                    TGT_GPR: gpr_w[wr_idx_i[IW*i +: IW]] =
                        masked_merge(gpr_w[wr_idx_i[IW*i +: IW]], eff_mask[i], wr_data_i[32*i +: 32]);
                    TGT_PSW: begin
                        psw_w       = masked_merge(psw_w, eff_mask[i], wr_data_i[32*i +: 32]);
                        psw_touched = 1'b1;
                    end
                    TGT_BPSW: bpsw_w = masked_merge(bpsw_w, eff_mask[i], wr_data_i[32*i +: 32]);
                    TGT_DPSW: dpsw_w = masked_merge(dpsw_w, eff_mask[i], wr_data_i[32*i +: 32]);
                    default: ;
                endcase
            end
        end
    end

    // accumulator replacements, slot order
    always_comb begin
        acc_n = acc_q;
        for (int k = 0; k < NACCW; k++) begin
            if (commit_i && int'(acc_count_i) > k)
                acc_n[acc_idx_i[AIW*k +: AIW]] = acc_data_i[64*k +: 64];
        end
    end

    wbm_trap_stack u_trap (
        .trap       (trap),
        .psw_touched(psw_touched),
        .psw_in     (psw_w),
        .bpsw_in    (bpsw_w),
        .dpsw_in    (dpsw_w),
        .sp_in      (gpr_w[NGPR-1]),
        .bank_in    (bank_q),
        .sel_in     (sel_q),
        .psw_out    (psw_n),
        .bpsw_out   (bpsw_n),
        .dpsw_out   (dpsw_n),
        .sp_out     (sp_n),
        .bank_out   (bank_n),
        .sel_out    (sel_n)
    );

    always_comb begin
        gpr_n         = gpr_w;
        gpr_n[NGPR-1] = sp_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gpr_q  <= '0;
            acc_q  <= '0;
            psw_q  <= '0;
            bpsw_q <= '0;
            dpsw_q <= '0;
            bank_q <= '0;
            sel_q  <= 1'b0;
        end else if (commit_i) begin
            gpr_q  <= gpr_n;
            acc_q  <= acc_n;
            psw_q  <= psw_n;
            bpsw_q <= bpsw_n;
            dpsw_q <= dpsw_n;
            bank_q <= bank_n;
            sel_q  <= sel_n;
        end
    end

    assign gpr_o     = gpr_q;
    assign acc_o     = acc_q;
    assign psw_o     = psw_q;
    assign bpsw_o    = bpsw_q;
    assign dpsw_o    = dpsw_q;
    assign sp_bank_o = bank_q;
    assign sp_sel_o  = sel_q;

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> ($stable(gpr_q) && $stable(acc_q) && $stable(psw_q) &&
                       $stable(bpsw_q) && $stable(dpsw_q) && $stable(bank_q) && $stable(sel_q)))
        else $error("state moved without a commit");

    assert_ord_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (commit_i && trap_i == TRAP_ORD) |=> ((psw_q & ~(BIT_DB | BIT_SM)) == '0))
        else $error("ordinary trap left extra status bits");

    assert_dbg_trap_R9: assert property (@(posedge clk) disable iff (rst)
        (commit_i && trap_i == TRAP_DBG) |=> (psw_q == BIT_DS))
        else $error("debug trap status word wrong");

    assert_bank_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (commit_i && (psw_touched || trap_i == TRAP_ORD || trap_i == TRAP_DBG))
            |=> (sel_q == psw_q[SM_LSB]))
        else $error("stack bank select does not follow SM");

endmodule

// File: tb/wbm_top_test.sv
`timescale 1ns/1ps
module wbm_top_test;
    localparam int NGPR = 4, NSLOT = 4, NACC = 2, NACCW = 2;
    localparam int IW = 2, AIW = 1, CW = 3, ACW = 2;
    localparam logic [31:0] TOP = 32'h8000_0000;
    localparam logic [31:0] B_SM = TOP >> 0, B_DB = TOP >> 3, B_DS = TOP >> 4;
    localparam logic [31:0] B_F0 = TOP >> 17, B_V = TOP >> 27, B_VA = TOP >> 29, B_C = TOP >> 31;
    localparam logic [31:0] FLAGS = (TOP >> 17) | (TOP >> 19) | (TOP >> 21) | (TOP >> 23) |
                                    (TOP >> 25) | B_V | B_VA | B_C;

    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic commit = 0, sysmv = 0;
    logic [CW-1:0] cnt = 0;
    logic [ACW-1:0] acnt = 0;
    logic [1:0] trap = 0;
    logic [1:0] kd [NSLOT];
    logic [IW-1:0] ix [NSLOT];
    logic [31:0] mk [NSLOT], dt [NSLOT];
    logic [AIW-1:0] aix [NACCW];
    logic [63:0] adt [NACCW];

    logic [2*NSLOT-1:0] kind_bus;
    logic [IW*NSLOT-1:0] idx_bus;
    logic [32*NSLOT-1:0] mask_bus, data_bus;
    logic [AIW*NACCW-1:0] aidx_bus;
    logic [64*NACCW-1:0] adata_bus;
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            kind_bus[2*i +: 2] = kd[i];
            idx_bus[IW*i +: IW] = ix[i];
            mask_bus[32*i +: 32] = mk[i];
            data_bus[32*i +: 32] = dt[i];
        end
        for (int k = 0; k < NACCW; k++) begin
            aidx_bus[AIW*k +: AIW] = aix[k];
            adata_bus[64*k +: 64] = adt[k];
        end
    end

    logic [32*NGPR-1:0] gpr_o;
    logic [64*NACC-1:0] acc_o;
    logic [31:0] psw_o, bpsw_o, dpsw_o;
    logic [63:0] bank_o;
    logic sel_o;

    wbm_top #(.NGPR(NGPR), .NSLOT(NSLOT), .NACC(NACC), .NACCW(NACCW)) uut (
        .clk(clk), .rst(rst), .commit_i(commit), .wr_count_i(cnt),
        .wr_kind_i(kind_bus), .wr_idx_i(idx_bus), .wr_mask_i(mask_bus), .wr_data_i(data_bus),
        .sys_move_i(sysmv), .acc_count_i(acnt), .acc_idx_i(aidx_bus), .acc_data_i(adata_bus),
        .trap_i(trap), .gpr_o(gpr_o), .acc_o(acc_o), .psw_o(psw_o), .bpsw_o(bpsw_o),
        .dpsw_o(dpsw_o), .sp_bank_o(bank_o), .sp_sel_o(sel_o));

    int errors = 0, checks = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_gpr [NGPR];
    logic [63:0] m_acc [NACC];
    logic [31:0] m_psw, m_bpsw, m_dpsw;
    logic [31:0] m_bank [2];
    logic m_sel;

    task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk64(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int r = 0; r < NGPR; r++) chk32(tag, $sformatf("gpr%0d", r), gpr_o[32*r +: 32], m_gpr[r]);
        for (int a = 0; a < NACC; a++) chk64(tag, $sformatf("acc%0d", a), acc_o[64*a +: 64], m_acc[a]);
        chk32(tag, "psw", psw_o, m_psw);
        chk32(tag, "bpsw", bpsw_o, m_bpsw);
        chk32(tag, "dpsw", dpsw_o, m_dpsw);
        chk32(tag, "bank0", bank_o[31:0], m_bank[0]);
        chk32(tag, "bank1", bank_o[63:32], m_bank[1]);
        chk32(tag, "sel", {31'b0, sel_o}, {31'b0, m_sel});
    endtask

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] m, logic [31:0] v);
        return (o & ~m) | (v & m);
    endfunction

    // sequential model of one commit
    task automatic model_step();
        bit touched = 0;
        logic [31:0] m, ov, sp, p;
        bit ns;
        for (int i = 0; i < int'(cnt); i++) begin
            m = mk[i];
            if (kd[i] == 2'd1 && !sysmv) begin
                for (int j = i + 1; j < int'(cnt); j++) begin
                    ov = mk[j] & mk[i] & FLAGS;
                    if (kd[j] == 2'd1 && ov != 0) begin
                        m = m & ~ov;
                        if (mk[j] & B_V) m = m & ~B_VA;
                    end
                end
            end
            case (kd[i])
                2'd0: m_gpr[ix[i]] = mrg(m_gpr[ix[i]], m, dt[i]);
                2'd1: begin m_psw = mrg(m_psw, m, dt[i]); touched = 1; end
                2'd2: m_bpsw = mrg(m_bpsw, m, dt[i]);
                default: m_dpsw = mrg(m_dpsw, m, dt[i]);
            endcase
        end
        for (int k = 0; k < int'(acnt); k++) m_acc[aix[k]] = adt[k];
        p = m_psw;
        if (trap == 2'd1) begin m_bpsw = p; m_psw = p & (B_DB | B_SM); touched = 1; end
        if (trap == 2'd2) begin m_dpsw = p; m_psw = B_DS; touched = 1; end
        ns = m_psw[31];
        if (touched && ns != m_sel) begin
            sp = m_gpr[NGPR-1];
            m_gpr[NGPR-1] = m_bank[ns];
            m_bank[m_sel] = sp;
            m_sel = ns;
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NSLOT; i++) begin kd[i] = 0; ix[i] = 0; mk[i] = 0; dt[i] = 0; end
        for (int k = 0; k < NACCW; k++) begin aix[k] = 0; adt[k] = 0; end
        cnt = 0; acnt = 0; trap = 0; sysmv = 0;
    endtask

    task automatic set_slot(int s, logic [1:0] k, logic [IW-1:0] x, logic [31:0] m, logic [31:0] d);
        kd[s] = k; ix[s] = x; mk[s] = m; dt[s] = d;
    endtask

    // slots are filled beforehand; commit at the next edge, compare after it
    task automatic fire(string tag);
        commit = 1;
        model_step();
        @(negedge clk);
        commit = 0;
        compare_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NGPR; r++) m_gpr[r] = 0;
        for (int a = 0; a < NACC; a++) m_acc[a] = 0;
        m_psw = 0; m_bpsw = 0; m_dpsw = 0; m_bank[0] = 0; m_bank[1] = 0; m_sel = 0;
        clear_slots();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        compare_all("R1");

        // R2: masked merge into general registers and shadow words
        clear_slots(); cnt = 3;
        set_slot(0, 0, 1, 32'hFFFF_FFFF, 32'hAAAA_5555);
        set_slot(1, 2, 0, 32'h0000_FFFF, 32'h1234_5678);
        set_slot(2, 3, 0, 32'hF000_000F, 32'hFFFF_FFFF);
        @(negedge clk); fire("R2");
        clear_slots(); cnt = 1;
        set_slot(0, 0, 1, 32'h00FF_00FF, 32'h0000_0000);
        @(negedge clk); fire("R2");
        chk32("R2", "gpr1 literal", gpr_o[63:32], 32'hAA00_5500);

        // R3: same register written twice in one packet
        clear_slots(); cnt = 2;
        set_slot(0, 0, 2, 32'hFFFF_0000, 32'h1111_1111);
        set_slot(1, 0, 2, 32'h0FF0_0000, 32'h2222_2222);
        @(negedge clk); fire("R3");
        chk32("R3", "gpr2 literal", gpr_o[95:64], 32'h1221_0000);

        // R4: later status write wins the shared flag only
        clear_slots(); cnt = 2;
        set_slot(0, 1, 0, B_F0 | B_C, 32'hFFFF_FFFF);
        set_slot(1, 1, 0, B_F0, 32'h0);
        @(negedge clk); fire("R4");
        chk32("R4", "psw literal", psw_o, B_C);

        // R5: later V suppresses earlier VA
        clear_slots(); cnt = 2;
        set_slot(0, 1, 0, B_VA | B_C, 32'hFFFF_FFFF);
        set_slot(1, 1, 0, B_V | B_C, 32'h0);
        @(negedge clk); fire("R5");
        chk32("R5", "psw literal", psw_o, 32'h0);

        // R6: system move disables arbitration
        clear_slots(); cnt = 2; sysmv = 1;
        set_slot(0, 1, 0, B_VA | B_C, 32'hFFFF_FFFF);
        set_slot(1, 1, 0, B_V | B_C, 32'h0);
        @(negedge clk); fire("R6");
        chk32("R6", "psw literal", psw_o, B_VA);

        // R7: accumulators, later slot wins
        clear_slots(); acnt = 2;
        aix[0] = 1; adt[0] = 64'h0123_4567_89AB_CDEF;
        aix[1] = 1; adt[1] = 64'hFEDC_BA98_7654_3210;
        @(negedge clk); fire("R7");
        chk64("R7", "acc1 literal", acc_o[127:64], 64'hFEDC_BA98_7654_3210);

        // R8 + R10: set all status bits, set SP, then ordinary trap swaps bank
        clear_slots(); cnt = 2;
        set_slot(0, 0, 3, 32'hFFFF_FFFF, 32'h0000_BEEF);
        set_slot(1, 1, 0, 32'hFFFF_FFFF & ~B_SM, 32'hFFFF_FFFF);
        @(negedge clk); fire("R8");
        clear_slots(); cnt = 1; trap = 1;
        set_slot(0, 1, 0, B_SM, 32'hFFFF_FFFF);
        @(negedge clk); fire("R8");
        chk32("R8", "psw literal", psw_o, B_DB | B_SM);
        chk32("R10", "bank0 saved sp", bank_o[31:0], 32'h0000_BEEF);

        // R9: debug trap, then reserved code
        clear_slots(); trap = 2;
        @(negedge clk); fire("R9");
        chk32("R9", "psw literal", psw_o, B_DS);
        chk32("R10", "sel after dbg", {31'b0, sel_o}, 32'h0);
        clear_slots(); trap = 3; cnt = 1;
        set_slot(0, 2, 0, 32'hFFFF_FFFF, 32'h5A5A_5A5A);
        @(negedge clk); fire("R9");

        // R11: busy inputs without commit
        clear_slots(); cnt = 4; trap = 1; acnt = 2;
        for (int i = 0; i < NSLOT; i++) set_slot(i, 2'(i), 2'(i), 32'hFFFF_FFFF, 32'hDEAD_0000 + i);
        adt[0] = 64'h1; adt[1] = 64'h2;
        repeat (3) @(negedge clk);
        compare_all("R11");

        // random sweep with colliding flags and frequent SM changes
        for (int n = 0; n < 3000; n++) begin
            clear_slots();
            cnt = CW'($urandom_range(0, NSLOT));
            acnt = ACW'($urandom_range(0, NACCW));
            sysmv = ($urandom_range(0, 5) == 0);
            trap = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            for (int i = 0; i < NSLOT; i++) begin
                set_slot(i, 2'($urandom_range(0, 3)), IW'($urandom_range(0, NGPR - 1)),
                         ($urandom_range(0, 1) != 0) ? ($urandom() & (FLAGS | B_SM)) : $urandom(),
                         $urandom());
                if ($urandom_range(0, 2) == 0) kd[i] = 2'd1;
            end
            for (int k = 0; k < NACCW; k++) begin
                aix[k] = AIW'($urandom_range(0, NACC - 1));
                adt[k] = {$urandom(), $urandom()};
            end
            @(negedge clk);
            fire(n[0] ? "R4 random" : "R5 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule